// File: doc/BRIEF.md
# Open-Row DRAM Command Sequencer

The sequencer accepts read and write references (each a bank, row and column) on a valid/ready port. It holds them in a small in-order queue and turns each one into the DRAM commands it needs. Every bank remembers the one row it has open. A reference that hits that row costs a single column command. A reference to an idle bank is preceded by an activate. A reference to a different row first closes the bank with a precharge, then activates the new row. All spacing comes from fixed cycle counts set by parameters.

The block has a single issue slot. Every command blocks the next one for its own latency. Precharges must also keep a minimum distance from one another. A free-running timer raises a refresh at a fixed interval. That refresh waits only for the command in flight, then goes ahead of any queued reference and leaves every bank idle. Each completed read or write pulses a completion flag in the same cycle as its command strobe.

Top module: `rowcmd_sched`

## Requirements
- R1: References are served strictly in arrival order. Each READ or WRITE strobe carries that reference's bank, row and column. ACTIVATE and PRECHARGE strobes carry the pending reference's bank and row.
- R2: After reset every bank is idle. A reference to an idle bank issues ACTIVATE, then its column command T_ACT (8) cycles later.
- R3: A reference whose row is already open in its bank issues READ or WRITE with no ACTIVATE before it.
- R4: A reference to a bank holding another row issues PRECHARGE, then ACTIVATE T_PRE (8) cycles later, then the column command T_ACT cycles after that.
- R5: `cmd_done` is high for exactly the cycles in which a READ or WRITE strobe is issued.
- R6: After a command, the next command waits its latency: ACTIVATE T_ACT, PRECHARGE T_PRE, READ T_RD (4), WRITE T_WR (4), REFRESH T_REF (64). The next command issues in the first cycle that all its limits allow.
- R7: Two PRECHARGE commands are at least T_PP (34) cycles apart.
- R8: `cmd_op` encodes 0 idle, 1 ACTIVATE, 2 PRECHARGE, 3 READ, 4 WRITE, 5 REFRESH. A REFRESH strobe carries zero bank, row and column.
- R9: The queue holds QDEPTH (4) references. `req_ready` is low exactly when it is full. A reference is taken on a clock edge with `req_valid` and `req_ready` both high.
- R10: A refresh falls due every REF_WIN/REF_CNT cycles, the first that many cycles after reset release. It closes every bank, so the next reference to any bank needs an ACTIVATE.
- R11: A due refresh is issued as soon as the current command's latency ends, ahead of any queued reference.
- R12: During and right after reset no command strobe or completion is driven and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Reference offered |
| req_ready | output | 1 | Queue has room |
| req_wr | input | 1 | 1 write, 0 read |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| cmd_valid | output | 1 | Command strobe |
| cmd_op | output | 3 | Command opcode |
| cmd_bank | output | BANK_W | Command bank |
| cmd_row | output | ROW_W | Command row |
| cmd_col | output | COL_W | Command column |
| cmd_done | output | 1 | Reference completed this cycle |

## Verification
A reference taken on an edge can produce its first command in the cycle right after that edge. Each later command is due at the latest of three points: the previous command plus its latency, the last precharge plus T_PP when the next command is a precharge, and the refresh due time. The scoreboard computes that exact cycle from the queued references and its own bank model, and checks the strobe at the falling edge of that cycle. A strobe that comes early, late or with other contents is a miscompare. Refresh due times are counted from the cycle in which reset is released.

// File: rtl/rowcmd_sched.sv
module rowcmd_sched #(
  parameter int NBANK   = 4,
  parameter int ROW_W   = 12,
  parameter int COL_W   = 8,
  parameter int QDEPTH  = 4,
  parameter int T_ACT   = 8,
  parameter int T_PRE   = 8,
  parameter int T_RD    = 4,
  parameter int T_WR    = 4,
  parameter int T_REF   = 64,
  parameter int T_PP    = 34,
  parameter int REF_WIN = 15600,
  parameter int REF_CNT = 2,
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_wr,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic              cmd_valid,
  output logic [2:0]        cmd_op,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [COL_W-1:0]  cmd_col,
  output logic              cmd_done
);
  localparam int QP_W    = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int QC_W    = $clog2(QDEPTH + 1);
  localparam int ENT_W   = 1 + BANK_W + ROW_W + COL_W;
  localparam int REF_INT = REF_WIN / REF_CNT;
  localparam int RT_W    = (REF_INT > 1) ? $clog2(REF_INT) : 1;
  localparam int M1      = (T_ACT > T_PRE) ? T_ACT : T_PRE;
  localparam int M2      = (T_RD > T_WR) ? T_RD : T_WR;
  localparam int M3      = (M1 > M2) ? M1 : M2;
  localparam int LAT_MAX = (M3 > T_REF) ? M3 : T_REF;
  localparam int W_W     = $clog2(LAT_MAX + 1);
  localparam int PP_W    = $clog2(T_PP + 1);

  localparam logic [2:0] OP_NOP = 3'd0, OP_ACT = 3'd1, OP_PRE = 3'd2,
                         OP_RD  = 3'd3, OP_WR  = 3'd4, OP_REF = 3'd5;
  localparam logic [PP_W-1:0] PP_LIM = PP_W'(T_PP - 1);
  localparam logic [RT_W-1:0] RT_LIM = RT_W'(REF_INT - 1);
  localparam logic [QP_W-1:0] QP_LAST = QP_W'(QDEPTH - 1);
  localparam logic [QC_W-1:0] QC_FULL = QC_W'(QDEPTH);

  logic [ENT_W-1:0]  q_mem [QDEPTH];
  logic [QP_W-1:0]   q_rd, q_wr;
  logic [QC_W-1:0]   q_cnt;
  logic [NBANK-1:0]  b_open;
  logic [ROW_W-1:0]  b_row [NBANK];
  logic [W_W-1:0]    wait_q, lat;
  logic [PP_W-1:0]   pp_age;
  logic [RT_W-1:0]   ref_tmr;
  logic              ref_pend;
  logic              h_wr, hit, push, is_ref;
  logic [BANK_W-1:0] h_bank;
  logic [ROW_W-1:0]  h_row;
  logic [COL_W-1:0]  h_col;
  logic [2:0]        op;

  assign {h_wr, h_bank, h_row, h_col} = q_mem[q_rd];
  assign req_ready = (q_cnt != QC_FULL);
  assign push      = req_valid && req_ready;
  assign hit       = b_open[h_bank] && (b_row[h_bank] == h_row);

  always_comb begin
    op = OP_NOP;
    if (wait_q == '0) begin
      if (ref_pend)                 op = OP_REF;
      else if (q_cnt != '0) begin
        if (hit)                    op = h_wr ? OP_WR : OP_RD;
        else if (!b_open[h_bank])   op = OP_ACT;
        else if (pp_age == PP_LIM)  op = OP_PRE;
      end
    end
  end

  always_comb begin
    case (op)
      OP_ACT:  lat = W_W'(T_ACT);
      OP_PRE:  lat = W_W'(T_PRE);
      OP_RD:   lat = W_W'(T_RD);
      OP_WR:   lat = W_W'(T_WR);
      OP_REF:  lat = W_W'(T_REF);
      default: lat = '0;
    endcase
  end

  assign is_ref    = (op == OP_REF);
  assign cmd_valid = (op != OP_NOP);
  assign cmd_op    = op;
  assign cmd_bank  = is_ref ? '0 : h_bank;
  assign cmd_row   = is_ref ? '0 : h_row;
  assign cmd_col   = is_ref ? '0 : h_col;
  assign cmd_done  = (op == OP_RD) || (op == OP_WR);

  always_ff @(posedge clk) begin
    if (push) q_mem[q_wr] <= {req_wr, req_bank, req_row, req_col};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_rd  <= '0;
      q_wr  <= '0;
      q_cnt <= '0;
    end else begin
      if (push)     q_wr <= (q_wr == QP_LAST) ? '0 : q_wr + 1'b1;
      if (cmd_done) q_rd <= (q_rd == QP_LAST) ? '0 : q_rd + 1'b1;
      case ({push, cmd_done})
        2'b10:   q_cnt <= q_cnt + 1'b1;
        2'b01:   q_cnt <= q_cnt - 1'b1;
        default: q_cnt <= q_cnt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q   <= '0;
      pp_age   <= PP_LIM;
      ref_tmr  <= '0;
      ref_pend <= 1'b0;
      b_open   <= '0;
      for (int i = 0; i < NBANK; i++) b_row[i] <= '0;
    end else begin
      if (cmd_valid)          wait_q <= lat - 1'b1;
      else if (wait_q != '0)  wait_q <= wait_q - 1'b1;

      if (op == OP_PRE)       pp_age <= '0;
      else if (pp_age != PP_LIM) pp_age <= pp_age + 1'b1;

      if (is_ref) ref_pend <= 1'b0;
      if (ref_tmr == RT_LIM) begin
        ref_tmr  <= '0;
        ref_pend <= 1'b1;
      end else begin
        ref_tmr  <= ref_tmr + 1'b1;
      end

      case (op)
        OP_REF: b_open <= '0;
        OP_PRE: b_open[h_bank] <= 1'b0;
        OP_ACT: begin
          b_open[h_bank] <= 1'b1;
          b_row[h_bank]  <= h_row;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rowcmd_sched_chk.sv
module rowcmd_sched_chk #(
  parameter int NBANK  = 4,
  parameter int ROW_W  = 12,
  parameter int QDEPTH = 4,
  parameter int T_ACT  = 8,
  parameter int T_PRE  = 8,
  parameter int T_RD   = 4,
  parameter int T_WR   = 4,
  parameter int T_REF  = 64,
  parameter int T_PP   = 34,
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              cmd_valid,
  input logic [2:0]        cmd_op,
  input logic [BANK_W-1:0] cmd_bank,
  input logic [ROW_W-1:0]  cmd_row,
  input logic              cmd_done
);
  localparam int QC_W = $clog2(QDEPTH + 1);

  logic [15:0]      gap, need, pgap, cur_lat;
  logic [NBANK-1:0] m_open;
  logic [ROW_W-1:0] m_row [NBANK];
  logic [QC_W-1:0]  occ;
  logic             is_act, is_pre, is_cas;

  assign is_act = cmd_valid && (cmd_op == 3'd1);
  assign is_pre = cmd_valid && (cmd_op == 3'd2);
  assign is_cas = cmd_valid && ((cmd_op == 3'd3) || (cmd_op == 3'd4));

  always_comb begin
    case (cmd_op)
      3'd1:    cur_lat = 16'(T_ACT);
      3'd2:    cur_lat = 16'(T_PRE);
      3'd3:    cur_lat = 16'(T_RD);
      3'd4:    cur_lat = 16'(T_WR);
      3'd5:    cur_lat = 16'(T_REF);
      default: cur_lat = 16'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap    <= 16'hFFFF;
      need   <= 16'd0;
      pgap   <= 16'hFFFF;
      m_open <= '0;
      occ    <= '0;
      for (int i = 0; i < NBANK; i++) m_row[i] <= '0;
    end else begin
      if (cmd_valid) begin
        gap  <= 16'd1;
        need <= cur_lat;
      end else if (gap != 16'hFFFF) gap <= gap + 16'd1;
      if (is_pre) pgap <= 16'd1;
      else if (pgap != 16'hFFFF) pgap <= pgap + 16'd1;
      if (cmd_valid && cmd_op == 3'd5) m_open <= '0;
      if (is_pre) m_open[cmd_bank] <= 1'b0;
      if (is_act) begin
        m_open[cmd_bank] <= 1'b1;
        m_row[cmd_bank]  <= cmd_row;
      end
      case ({req_valid && req_ready, cmd_done})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  p_act_idle_r2:   assert property (@(posedge clk) disable iff (!rst_n)
                     is_act |-> !m_open[cmd_bank]);
  p_cas_hit_r3:    assert property (@(posedge clk) disable iff (!rst_n)
                     is_cas |-> (m_open[cmd_bank] && m_row[cmd_bank] == cmd_row));
  p_pre_miss_r4:   assert property (@(posedge clk) disable iff (!rst_n)
                     is_pre |-> (m_open[cmd_bank] && m_row[cmd_bank] != cmd_row));
  p_done_pop_r5:   assert property (@(posedge clk) disable iff (!rst_n)
                     cmd_done |-> (is_cas && occ != '0));
  p_cmd_gap_r6:    assert property (@(posedge clk) disable iff (!rst_n)
                     cmd_valid |-> gap >= need);
  p_pre_space_r7:  assert property (@(posedge clk) disable iff (!rst_n)
                     is_pre |-> pgap >= 16'(T_PP));
  p_ready_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
                     req_ready == (occ != QC_W'(QDEPTH)));
endmodule

bind rowcmd_sched rowcmd_sched_chk #(
  .NBANK(NBANK), .ROW_W(ROW_W), .QDEPTH(QDEPTH), .T_ACT(T_ACT), .T_PRE(T_PRE),
  .T_RD(T_RD), .T_WR(T_WR), .T_REF(T_REF), .T_PP(T_PP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
  .cmd_row(cmd_row), .cmd_done(cmd_done)
);

// File: tb/rowcmd_sched_tb.sv
module rowcmd_sched_tb;
  localparam int NB = 4, RW = 8, CW = 6, QD = 4;
  localparam int TA = 8, TP = 8, TR = 4, TW = 4, TF = 64, TI = 34;
  localparam int RI = 600;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_wr = 1'b0;
  logic [1:0] req_bank = '0;
  logic [RW-1:0] req_row = '0;
  logic [CW-1:0] req_col = '0;
  logic req_ready, cmd_valid, cmd_done;
  logic [2:0] cmd_op;
  logic [1:0] cmd_bank;
  logic [RW-1:0] cmd_row;
  logic [CW-1:0] cmd_col;

  always #5 clk = ~clk;

  rowcmd_sched #(.NBANK(NB), .ROW_W(RW), .COL_W(CW), .QDEPTH(QD), .T_ACT(TA),
    .T_PRE(TP), .T_RD(TR), .T_WR(TW), .T_REF(TF), .T_PP(TI),
    .REF_WIN(2*RI), .REF_CNT(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_wr(req_wr), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
    .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_done(cmd_done));

  typedef struct packed {
    logic wr; logic [1:0] bank; logic [RW-1:0] row; logic [CW-1:0] col; logic [31:0] elig;
  } req_t;

  req_t mq[$];
  int n_vec = 0, n_bad = 0, acc = 0, n_done = 0, n_ref = 0, stalls = 0;
  int prev_end = 0, last_pre = -1000, next_due = 0, prev_op = 0;
  bit running = 0, ended = 0;
  bit m_open[NB];
  logic [RW-1:0] m_row[NB];

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic ready_check();
    int occ;
    #1;
    occ = acc - n_done + (cmd_done ? 1 : 0);
    check(req_ready == (occ < QD), "R9", "ready vs queue fill", req_ready, occ < QD);
    if (!req_ready) stalls++;
  endtask

  task automatic send(bit wr, int b, int r, int c);
    bit got = 0;
    req_t e;
    @(negedge clk);
    req_valid = 1'b1; req_wr = wr; req_bank = b[1:0]; req_row = r[RW-1:0]; req_col = c[CW-1:0];
    while (!got) begin
      ready_check();
      got = req_ready;
      @(posedge clk);
      if (got) begin
        e.wr = wr; e.bank = b[1:0]; e.row = r[RW-1:0]; e.col = c[CW-1:0];
        e.elig = ($time + 5) / 10;
        mq.push_back(e);
        acc++;
      end else @(negedge clk);
    end
  endtask

  task automatic idle_until(int cyc);
    @(negedge clk);
    req_valid = 1'b0;
    while ($time / 10 < cyc) @(negedge clk);
  endtask

  // scoreboard monitor: expected command and its exact cycle from R1-R11 rules
  always @(negedge clk) begin : mon
    int t, ref_at, earliest, et, lat;
    logic [2:0] eop;
    req_t h;
    string ttag;
    if (running) begin
      t = $time / 10;
      if (cmd_done) n_done++;
      if (cmd_valid) begin
        ref_at = imax(next_due, prev_end);
        earliest = 0; eop = 3'd5; et = ref_at;
        if (mq.size() > 0) begin
          h = mq[0];
          if (m_open[h.bank] && m_row[h.bank] == h.row) eop = h.wr ? 3'd4 : 3'd3;
          else if (!m_open[h.bank]) eop = 3'd1;
          else eop = 3'd2;
          earliest = imax(prev_end, int'(h.elig));
          if (eop == 3'd2) earliest = imax(earliest, last_pre + TI);
          if (ref_at <= earliest) begin eop = 3'd5; et = ref_at; end
          else et = earliest;
        end
        case (eop)
          3'd1: ttag = "R2";
          3'd2: ttag = "R4";
          3'd5: ttag = "R10";
          default: ttag = "R3";
        endcase
        check(cmd_op == eop, ttag, "opcode", cmd_op, eop);
        if (eop == 3'd5) ttag = "R11";
        else if (eop == 3'd2) ttag = "R7";
        else if (prev_op == 1) ttag = "R2";
        else ttag = "R6";
        check(t == et, ttag, "issue cycle", t, et);
        check(cmd_done == (eop == 3'd3 || eop == 3'd4), "R5", "done pulse", cmd_done, eop == 3'd3 || eop == 3'd4);
        if (eop == 3'd5) begin
          check(cmd_bank == 0 && cmd_row == 0 && cmd_col == 0, "R8", "refresh fields zero", cmd_row, 0);
          for (int i = 0; i < NB; i++) m_open[i] = 0;
          next_due += RI; n_ref++; lat = TF;
        end else begin
          check(cmd_bank == h.bank, "R1", "bank field", cmd_bank, h.bank);
          check(cmd_row == h.row, "R1", "row field", cmd_row, h.row);
          if (eop == 3'd3 || eop == 3'd4) begin
            check(cmd_col == h.col, "R1", "column field", cmd_col, h.col);
            void'(mq.pop_front());
            lat = (eop == 3'd3) ? TR : TW;
          end else if (eop == 3'd1) begin
            m_open[h.bank] = 1; m_row[h.bank] = h.row; lat = TA;
          end else begin
            m_open[h.bank] = 0; last_pre = et; lat = TP;
          end
        end
        prev_end = et + lat;
        prev_op = eop;
      end else if (cmd_done) begin
        check(0, "R5", "done without strobe", 1, 0);
      end
    end
  end

  initial begin
    for (int i = 0; i < NB; i++) begin m_open[i] = 0; m_row[i] = '0; end
    repeat (2) @(negedge clk);
    check(cmd_valid == 1'b0, "R12", "strobe in reset", cmd_valid, 0);
    check(req_ready == 1'b1, "R12", "ready in reset", req_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;
    next_due = $time / 10 + RI;
    running = 1;
    #1;
    check(cmd_valid == 1'b0 && cmd_done == 1'b0, "R12", "no strobe after reset", cmd_valid, 0);
    // phase A: idle bank, hit, second bank, misses with precharge spacing, full queue
    send(0, 0, 5, 1);
    send(0, 0, 5, 2);
    send(1, 1, 7, 3);
    send(0, 0, 9, 4);
    send(1, 0, 3, 5);
    send(0, 1, 7, 6);
    send(0, 2, 1, 7);
    send(1, 1, 8, 8);
    send(0, 3, 2, 9);
    send(1, 2, 1, 10);
    send(0, 0, 4, 11);
    idle_until(700);
    // phase B: after refresh the bank is idle again
    send(0, 0, 4, 12);
    idle_until(1188);
    // phase C: refresh falls due inside a busy stream
    send(0, 0, 6, 13);
    send(0, 0, 7, 14);
    send(1, 1, 2, 15);
    send(1, 1, 2, 16);
    send(0, 2, 9, 17);
    send(1, 2, 3, 18);
    idle_until(1900);
    check(stalls > 0, "R9", "queue reached full", stalls, 1);
    check(n_ref == 3, "R10", "refresh count", n_ref, 3);
    check(n_done == acc && mq.size() == 0, "R1", "all references retired", n_done, acc);
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!ended) begin
      ended = 1;
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule